// File: doc/BRIEF.md
# Exception Pending and Active Tracker

This block keeps the pending, enabled and active state of the system exceptions (numbers 2 to 15) and of `NUM_EXT` external interrupt lines, which take exception numbers from 16 upward. Every cycle it works out the best pending candidate. When the core acknowledges, that candidate moves from pending to active and its number is returned. When the core signals completion, the current exception is retired and the one it preempted becomes active again. A small nesting stack holds the preempted exceptions.

Software reaches the block through a word-addressed register port. Writes take effect on the next clock edge and reads are combinational. The port gives a packed status word with pend set and clear bits, a software trigger, an interrupt-count word, priority words for system handlers and for external lines, external enable words, and a handler status and enable word. Fault detection, vector fetch and context stacking are done elsewhere and only meet this block through its pend inputs and its handshakes.

Top module: `exc_tracker`

## Requirements
- R1: After reset nothing is pending or active. All priorities and enables are zero. The status word (address 0) reads 0x0000_0800 and an acknowledge returns 1023.
- R2: While `irq_i[n]` is high at a clock edge, exception 16+n becomes pending. Once external line n is enabled (address 8+n/32, bit n%32) it is chosen and acknowledged as number 16+n.
- R3: An acknowledge with no eligible candidate returns 1023 and changes nothing. Otherwise `ack_vec_o` returns the chosen number in the same cycle, and from the next cycle that exception is active, no longer pending, and shown on `act_vec_o`.
- R4: A pending, enabled, not-yet-active exception is eligible. Exception 2 beats everything, exception 3 comes next, and the rest compare by priority value, where a lower value wins. On equal values the lower exception number wins.
- R5: A completion whose `cmpl_vec_i` equals the current active number retires that exception and restores the one it preempted (0 if none). A completion for any other number is ignored.
- R6: When `STACK_DEPTH` preempted exceptions are already held, further acknowledges return 1023. An acknowledge in the same cycle as a completion also returns 1023, and the completion is performed.
- R7: Status word at address 0: bits 8:0 hold the active number (0 if none), bit 11 is set when none is active or nothing is held beneath the active one, bits 20:12 hold the best candidate (0 if none), bit 22 shows any external pending, and bits 26, 28 and 31 show exceptions 15, 14 and 2 pending.
- R8: A write to address 0 works as follows. Bit 31 pends exception 2. Bit 28 pends exception 14, and otherwise bit 27 clears it. Bit 26 pends exception 15, and otherwise bit 25 clears it.
- R9: A write to address 1 pends external line `wdata[8:0]` only when that id is below `NUM_EXT`. Larger ids have no effect.
- R10: Addresses 3, 4 and 5 hold the priorities of exceptions 4–7, 8–11 and 12–15, one per byte, with byte 0 holding the lowest number. Each byte keeps its low `PRIO_W` bits and reads back zero-extended. External priorities sit at address 8+NUM_EXT/32+k, with byte b holding line 4k+b.
- R11: Handler word at address 6. Active bits are 0, 1, 3, 7, 8, 10 and 11 for exceptions 4, 5, 6, 11, 12, 14 and 15. Pending bits are 12, 13, 14 and 15 for exceptions 6, 4, 5 and 11. Bits 16–18 are writable enables for exceptions 4, 5 and 6. A pending exception 4, 5 or 6 whose enable is clear is not chosen.
- R12: Address 2 reads NUM_EXT/32−1, and the external enable words read back as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| irq_i | input | NUM_EXT | External interrupt request lines, pend while high |
| sys_pend_i | input | 16 | Pend strobes for system exceptions 0–15 (unimplemented numbers ignored) |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | ADDR_W | Register word address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for `reg_addr_i` (combinational) |
| ack_req_i | input | 1 | Acknowledge request from the core |
| ack_vec_o | output | 10 | Number acknowledged this cycle, 1023 if none |
| cmpl_req_i | input | 1 | Completion request from the core |
| cmpl_vec_i | input | 10 | Number being completed |
| act_vec_o | output | 10 | Current active exception, 0 if none |
| pend_vec_o | output | 10 | Best eligible candidate, 0 if none |
| pend_valid_o | output | 1 | A candidate exists |

## Verification
The bench builds the block with NUM_EXT=32, PRIO_W=4 and STACK_DEPTH=2. With 32 lines, the software-trigger ids 31 and 32 sit on either side of the accept limit, and the interrupt-count word reads zero. A 4-bit priority field makes the truncation of written bytes visible on readback. A two-entry stack lets a short sequence of four acknowledges reach the refusal at full nesting. It also exercises restore-on-completion at every depth.

// File: rtl/exc_pkg.sv
package exc_pkg;
  localparam int unsigned SYS_CNT    = 16;
  localparam int unsigned VEC_W      = 10;
  localparam logic [VEC_W-1:0] VEC_NONE = 10'd1023;

  localparam int unsigned EXC_NMI    = 2;
  localparam int unsigned EXC_HARD   = 3;
  localparam int unsigned EXC_MEM    = 4;
  localparam int unsigned EXC_BUS    = 5;
  localparam int unsigned EXC_USAGE  = 6;
  localparam int unsigned EXC_SVC    = 11;
  localparam int unsigned EXC_DEBUG  = 12;
  localparam int unsigned EXC_PENDSV = 14;
  localparam int unsigned EXC_TICK   = 15;

  // system numbers that exist: 2,3,4,5,6,11,12,14,15
  localparam logic [SYS_CNT-1:0] SYS_IMPL = 16'hD87C;

  // register word map
  localparam int unsigned W_CTRL    = 0;
  localparam int unsigned W_SWTRIG  = 1;
  localparam int unsigned W_TYPE    = 2;
  localparam int unsigned W_SPRI0   = 3;
  localparam int unsigned W_HSTAT   = 6;
  localparam int unsigned W_EN_BASE = 8;

  typedef enum logic [1:0] {
    CLS_NMI  = 2'd0,
    CLS_HARD = 2'd1,
    CLS_CFG  = 2'd2
  } exc_class_e;
endpackage

// File: rtl/exc_prio_store.sv
module exc_prio_store
  import exc_pkg::*;
#(
  parameter int unsigned NUM_EXT = 64,
  parameter int unsigned PRIO_W  = 8,
  parameter int unsigned PR_BASE = 10,
  parameter int unsigned ADDR_W  = 5,
  localparam int unsigned NUM_EXC  = SYS_CNT + NUM_EXT,
  localparam int unsigned PR_WORDS = NUM_EXT / 4,
  localparam int unsigned SYS_CFG  = 12
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             we_i,
  input  logic [ADDR_W-1:0]                addr_i,
  input  logic [31:0]                      wdata_i,
  output logic                             hit_o,
  output logic [31:0]                      rdata_o,
  output logic [NUM_EXC-1:0][PRIO_W-1:0]   prio_o
);
  logic [SYS_CFG-1:0][PRIO_W-1:0] sys_pr;
  logic [NUM_EXT-1:0][PRIO_W-1:0] ext_pr;

  // system handler priorities, exceptions 4..15
  for (genvar g = 0; g < SYS_CFG; g++) begin : g_sys
    localparam int unsigned WRD = W_SPRI0 + g / 4;
    localparam int unsigned BYT = g % 4;
    logic              wen;
    logic [PRIO_W-1:0] q;
    assign wen = we_i && (addr_i == ADDR_W'(WRD));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   q <= '0;
      else if (wen) q <= wdata_i[8*BYT +: PRIO_W];
    end
    assign sys_pr[g] = q;
  end

  // external line priorities
  for (genvar n = 0; n < NUM_EXT; n++) begin : g_ext
    localparam int unsigned WRD = PR_BASE + n / 4;
    localparam int unsigned BYT = n % 4;
    logic              wen;
    logic [PRIO_W-1:0] q;
    assign wen = we_i && (addr_i == ADDR_W'(WRD));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   q <= '0;
      else if (wen) q <= wdata_i[8*BYT +: PRIO_W];
    end
    assign ext_pr[n] = q;
  end

  for (genvar e = 0; e < NUM_EXC; e++) begin : g_map
    if (e < 4) begin : g_fixed
      assign prio_o[e] = '0;
    end else if (e < SYS_CNT) begin : g_sysm
      assign prio_o[e] = sys_pr[e-4];
    end else begin : g_extm
      assign prio_o[e] = ext_pr[e-SYS_CNT];
    end
  end

  always_comb begin
    hit_o   = 1'b0;
    rdata_o = '0;
    for (int g = 0; g < 3; g++) begin
      if (addr_i == ADDR_W'(W_SPRI0 + g)) begin
        hit_o = 1'b1;
        for (int b = 0; b < 4; b++) rdata_o[8*b +: PRIO_W] = sys_pr[4*g+b];
      end
    end
    for (int k = 0; k < PR_WORDS; k++) begin
      if (addr_i == ADDR_W'(PR_BASE + k)) begin
        hit_o = 1'b1;
        for (int b = 0; b < 4; b++) rdata_o[8*b +: PRIO_W] = ext_pr[4*k+b];
      end
    end
  end
endmodule

// File: rtl/exc_pick.sv
module exc_pick
  import exc_pkg::*;
#(
  parameter int unsigned NUM_EXC = 80,
  parameter int unsigned PRIO_W  = 8,
  localparam int unsigned IDX_W  = $clog2(NUM_EXC),
  localparam int unsigned KEY_W  = PRIO_W + 2
) (
  input  logic [NUM_EXC-1:0]               cand_i,
  input  logic [NUM_EXC-1:0][PRIO_W-1:0]   prio_i,
  output logic                             valid_o,
  output logic [IDX_W-1:0]                 idx_o
);
  logic [KEY_W-1:0] best_key;
  logic [KEY_W-1:0] key;

  // ascending scan with strict compare: ties keep the lower number
  always_comb begin
    valid_o  = 1'b0;
    idx_o    = '0;
    best_key = '1;
    key      = '1;
    for (int e = 0; e < NUM_EXC; e++) begin
      if (e == EXC_NMI)       key = {CLS_NMI,  {PRIO_W{1'b0}}};
      else if (e == EXC_HARD) key = {CLS_HARD, {PRIO_W{1'b0}}};
      else                    key = {CLS_CFG,  prio_i[e]};
      if (cand_i[e] && (!valid_o || key < best_key)) begin
        valid_o  = 1'b1;
        best_key = key;
        idx_o    = IDX_W'(e);
      end
    end
  end
endmodule

// File: rtl/exc_nest_stack.sv
module exc_nest_stack #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned W     = 7,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1),
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push_i,
  input  logic         pop_i,
  input  logic [W-1:0] data_i,
  output logic [W-1:0] top_o,
  output logic         empty_o,
  output logic         full_o
);
  logic [DEPTH-1:0][W-1:0] mem_q;
  logic [CNT_W-1:0]        sp_q, sp_d;
  logic                    sp_en;
  logic [PTR_W-1:0]        wr_ptr, top_ptr;

  assign empty_o = (sp_q == '0);
  assign full_o  = (sp_q == CNT_W'(DEPTH));
  assign wr_ptr  = PTR_W'(sp_q);
  assign top_ptr = PTR_W'(sp_q - CNT_W'(1));
  assign top_o   = empty_o ? '0 : mem_q[top_ptr];

  always_comb begin
    sp_en = push_i || pop_i;
    sp_d  = sp_q;
    if (push_i)     sp_d = sp_q + CNT_W'(1);
    else if (pop_i) sp_d = sp_q - CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     sp_q <= '0;
    else if (sp_en) sp_q <= sp_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      mem_q <= '0;
    else if (push_i) mem_q[wr_ptr] <= data_i;
  end

  AST_STACK_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    full_o |-> !push_i); // R6
  AST_STACK_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    empty_o |-> !pop_i); // R5
  AST_STACK_ONE_OP: assert property (@(posedge clk) disable iff (!rst_n)
    !(push_i && pop_i)); // R6
endmodule

// File: rtl/exc_tracker.sv
module exc_tracker
  import exc_pkg::*;
#(
  parameter int unsigned NUM_EXT     = 64,
  parameter int unsigned PRIO_W      = 8,
  parameter int unsigned STACK_DEPTH = 8,
  localparam int unsigned NUM_EXC  = SYS_CNT + NUM_EXT,
  localparam int unsigned EN_WORDS = NUM_EXT / 32,
  localparam int unsigned PR_BASE  = W_EN_BASE + EN_WORDS,
  localparam int unsigned PR_WORDS = NUM_EXT / 4,
  localparam int unsigned ADDR_W   = $clog2(PR_BASE + PR_WORDS),
  localparam int unsigned IDX_W    = $clog2(NUM_EXC)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_EXT-1:0]  irq_i,
  input  logic [SYS_CNT-1:0]  sys_pend_i,
  input  logic                reg_we_i,
  input  logic [ADDR_W-1:0]   reg_addr_i,
  input  logic [31:0]         reg_wdata_i,
  output logic [31:0]         reg_rdata_o,
  input  logic                ack_req_i,
  output logic [VEC_W-1:0]    ack_vec_o,
  input  logic                cmpl_req_i,
  input  logic [VEC_W-1:0]    cmpl_vec_i,
  output logic [VEC_W-1:0]    act_vec_o,
  output logic [VEC_W-1:0]    pend_vec_o,
  output logic                pend_valid_o
);
  // reset: asserted asynchronously, released on the clock
  logic [1:0] rs_q;
  logic       rst_sn;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_sn = rs_q[1];

  logic [NUM_EXC-1:0] pend_q, pend_d;
  logic [NUM_EXC-1:0] act_q, act_d;
  logic [NUM_EXC-1:0] en_vec, cand;
  logic [NUM_EXT-1:0] ext_en_q, ext_en_d;
  logic [2:0]         sen_q, sen_d;
  logic [IDX_W-1:0]   cur_q, cur_d;
  logic               ext_en_we, sen_we, core_en;

  logic [NUM_EXC-1:0][PRIO_W-1:0] prio;
  logic                           pr_hit;
  logic [31:0]                    pr_rdata;
  logic                           best_valid;
  logic [IDX_W-1:0]               best_idx;
  logic                           stk_empty, stk_full, stk_push, stk_pop;
  logic [IDX_W-1:0]               stk_top;
  logic                           cur_busy, do_ack, do_cmpl;
  logic                           ctrl_we, sw_we;
  logic [8:0]                     sw_id;

  exc_prio_store #(
    .NUM_EXT (NUM_EXT),
    .PRIO_W  (PRIO_W),
    .PR_BASE (PR_BASE),
    .ADDR_W  (ADDR_W)
  ) i_prio (
    .clk     (clk),
    .rst_n   (rst_sn),
    .we_i    (reg_we_i),
    .addr_i  (reg_addr_i),
    .wdata_i (reg_wdata_i),
    .hit_o   (pr_hit),
    .rdata_o (pr_rdata),
    .prio_o  (prio)
  );

  // eligibility
  always_comb begin
    en_vec = '0;
    for (int e = 0; e < SYS_CNT; e++) en_vec[e] = SYS_IMPL[e];
    en_vec[EXC_MEM]   = sen_q[0];
    en_vec[EXC_BUS]   = sen_q[1];
    en_vec[EXC_USAGE] = sen_q[2];
    en_vec[NUM_EXC-1:SYS_CNT] = ext_en_q;
  end
  assign cand = pend_q & en_vec & ~act_q;

  exc_pick #(
    .NUM_EXC (NUM_EXC),
    .PRIO_W  (PRIO_W)
  ) i_pick (
    .cand_i  (cand),
    .prio_i  (prio),
    .valid_o (best_valid),
    .idx_o   (best_idx)
  );

  exc_nest_stack #(
    .DEPTH (STACK_DEPTH),
    .W     (IDX_W)
  ) i_stack (
    .clk     (clk),
    .rst_n   (rst_sn),
    .push_i  (stk_push),
    .pop_i   (stk_pop),
    .data_i  (cur_q),
    .top_o   (stk_top),
    .empty_o (stk_empty),
    .full_o  (stk_full)
  );

  // core handshakes
  assign cur_busy = (cur_q != '0);
  assign do_cmpl  = cmpl_req_i && cur_busy && (cmpl_vec_i == VEC_W'(cur_q));
  assign do_ack   = ack_req_i && !cmpl_req_i && best_valid && !(cur_busy && stk_full);
  assign stk_push = do_ack && cur_busy;
  assign stk_pop  = do_cmpl && !stk_empty;
  assign core_en  = do_ack || do_cmpl;

  assign ack_vec_o    = do_ack ? VEC_W'(best_idx) : VEC_NONE;
  assign act_vec_o    = VEC_W'(cur_q);
  assign pend_vec_o   = best_valid ? VEC_W'(best_idx) : '0;
  assign pend_valid_o = best_valid;

  // register writes
  assign ctrl_we   = reg_we_i && (reg_addr_i == ADDR_W'(W_CTRL));
  assign sw_we     = reg_we_i && (reg_addr_i == ADDR_W'(W_SWTRIG));
  assign sw_id     = reg_wdata_i[8:0];
  assign sen_we    = reg_we_i && (reg_addr_i == ADDR_W'(W_HSTAT));
  assign sen_d     = reg_wdata_i[18:16];

  always_comb begin
    ext_en_we = 1'b0;
    ext_en_d  = ext_en_q;
    for (int k = 0; k < EN_WORDS; k++) begin
      if (reg_we_i && (reg_addr_i == ADDR_W'(W_EN_BASE + k))) begin
        ext_en_we         = 1'b1;
        ext_en_d[32*k +: 32] = reg_wdata_i;
      end
    end
  end

  // pending next state: ack clear, then software, then hardware sets
  always_comb begin
    pend_d = pend_q;
    if (do_ack) pend_d[best_idx] = 1'b0;
    if (ctrl_we) begin
      if (reg_wdata_i[31]) pend_d[EXC_NMI] = 1'b1;
      if (reg_wdata_i[28])      pend_d[EXC_PENDSV] = 1'b1;
      else if (reg_wdata_i[27]) pend_d[EXC_PENDSV] = 1'b0;
      if (reg_wdata_i[26])      pend_d[EXC_TICK] = 1'b1;
      else if (reg_wdata_i[25]) pend_d[EXC_TICK] = 1'b0;
    end
    if (sw_we && (int'(sw_id) < NUM_EXT)) pend_d[SYS_CNT + int'(sw_id)] = 1'b1;
    pend_d[SYS_CNT-1:0]       = (pend_d[SYS_CNT-1:0] | sys_pend_i) & SYS_IMPL;
    pend_d[NUM_EXC-1:SYS_CNT] = pend_d[NUM_EXC-1:SYS_CNT] | irq_i;
  end

  // active next state
  always_comb begin
    act_d = act_q;
    cur_d = cur_q;
    if (do_cmpl) begin
      act_d[cur_q] = 1'b0;
      cur_d        = stk_top;
    end else if (do_ack) begin
      act_d[best_idx] = 1'b1;
      cur_d           = best_idx;
    end
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) pend_q <= '0;
    else         pend_q <= pend_d;
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      act_q <= '0;
      cur_q <= '0;
    end else if (core_en) begin
      act_q <= act_d;
      cur_q <= cur_d;
    end
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn)        ext_en_q <= '0;
    else if (ext_en_we) ext_en_q <= ext_en_d;
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn)     sen_q <= '0;
    else if (sen_we) sen_q <= sen_d;
  end

  // read mux
  logic [31:0] stat_word, hstat_word;
  always_comb begin
    stat_word        = '0;
    stat_word[8:0]   = 9'(cur_q);
    stat_word[11]    = !cur_busy || stk_empty;
    stat_word[20:12] = best_valid ? 9'(best_idx) : 9'd0;
    stat_word[22]    = |pend_q[NUM_EXC-1:SYS_CNT];
    stat_word[26]    = pend_q[EXC_TICK];
    stat_word[28]    = pend_q[EXC_PENDSV];
    stat_word[31]    = pend_q[EXC_NMI];

    hstat_word       = '0;
    hstat_word[0]    = act_q[EXC_MEM];
    hstat_word[1]    = act_q[EXC_BUS];
    hstat_word[3]    = act_q[EXC_USAGE];
    hstat_word[7]    = act_q[EXC_SVC];
    hstat_word[8]    = act_q[EXC_DEBUG];
    hstat_word[10]   = act_q[EXC_PENDSV];
    hstat_word[11]   = act_q[EXC_TICK];
    hstat_word[12]   = pend_q[EXC_USAGE];
    hstat_word[13]   = pend_q[EXC_MEM];
    hstat_word[14]   = pend_q[EXC_BUS];
    hstat_word[15]   = pend_q[EXC_SVC];
    hstat_word[18:16] = sen_q;
  end

  always_comb begin
    reg_rdata_o = '0;
    if (pr_hit) reg_rdata_o = pr_rdata;
    else if (reg_addr_i == ADDR_W'(W_CTRL))  reg_rdata_o = stat_word;
    else if (reg_addr_i == ADDR_W'(W_TYPE))  reg_rdata_o = 32'(EN_WORDS - 1);
    else if (reg_addr_i == ADDR_W'(W_HSTAT)) reg_rdata_o = hstat_word;
    for (int k = 0; k < EN_WORDS; k++)
      if (reg_addr_i == ADDR_W'(W_EN_BASE + k)) reg_rdata_o = ext_en_q[32*k +: 32];
  end

  AST_ACK_NONE_SENTINEL: assert property (@(posedge clk) disable iff (!rst_sn)
    (ack_req_i && !pend_valid_o) |-> (ack_vec_o == VEC_NONE)); // R3
  AST_ACK_MAKES_ACTIVE: assert property (@(posedge clk) disable iff (!rst_sn)
    (ack_vec_o != VEC_NONE) |=> (act_vec_o == $past(ack_vec_o))); // R3
  AST_CUR_IS_ACTIVE: assert property (@(posedge clk) disable iff (!rst_sn)
    cur_busy |-> act_q[cur_q]); // R5
  AST_NMI_WINS: assert property (@(posedge clk) disable iff (!rst_sn)
    (pend_q[EXC_NMI] && !act_q[EXC_NMI]) |-> (pend_vec_o == VEC_W'(EXC_NMI))); // R4
  AST_CMPL_RESTORES: assert property (@(posedge clk) disable iff (!rst_sn)
    (do_cmpl && !stk_empty) |=> (act_vec_o == $past(VEC_W'(stk_top)))); // R5
  AST_ACK_YIELDS_TO_CMPL: assert property (@(posedge clk) disable iff (!rst_sn)
    (ack_req_i && cmpl_req_i) |-> (ack_vec_o == VEC_NONE)); // R6
endmodule

// File: tb/test_exc_tracker.sv
module test_exc_tracker;
  localparam int unsigned NEXT  = 32;
  localparam int unsigned PW    = 4;
  localparam int unsigned DEPTH = 2;
  localparam int unsigned AW    = 5;
  localparam int unsigned PRB   = 9;
  localparam logic [9:0]  NONE  = 10'd1023;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [NEXT-1:0] irq_i = '0;
  logic [15:0]     sys_pend_i = '0;
  logic            reg_we_i = 1'b0;
  logic [AW-1:0]   reg_addr_i = '0;
  logic [31:0]     reg_wdata_i = '0;
  logic [31:0]     reg_rdata_o;
  logic            ack_req_i = 1'b0;
  logic [9:0]      ack_vec_o;
  logic            cmpl_req_i = 1'b0;
  logic [9:0]      cmpl_vec_i = '0;
  logic [9:0]      act_vec_o;
  logic [9:0]      pend_vec_o;
  logic            pend_valid_o;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;

  exc_tracker #(.NUM_EXT(NEXT), .PRIO_W(PW), .STACK_DEPTH(DEPTH)) i_exc_tracker (
    .clk, .rst_n, .irq_i, .sys_pend_i, .reg_we_i, .reg_addr_i, .reg_wdata_i,
    .reg_rdata_o, .ack_req_i, .ack_vec_o, .cmpl_req_i, .cmpl_vec_i,
    .act_vec_o, .pend_vec_o, .pend_valid_o
  );

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s got %h exp %h", tag, got, exp);
    end
  endtask

  task automatic wr(int a, logic [31:0] d);
    @(negedge clk);
    reg_we_i = 1'b1; reg_addr_i = AW'(a); reg_wdata_i = d;
    @(negedge clk);
    reg_we_i = 1'b0; reg_wdata_i = '0;
  endtask

  task automatic rd(int a, logic [31:0] exp, string tag);
    @(negedge clk);
    reg_addr_i = AW'(a);
    #1 chk(tag, reg_rdata_o, exp);
  endtask

  task automatic ack(logic [9:0] exp, string tag);
    logic [9:0] prev;
    @(negedge clk);
    prev = act_vec_o;
    ack_req_i = 1'b1;
    #1 chk(tag, 32'(ack_vec_o), 32'(exp));
    @(negedge clk);
    ack_req_i = 1'b0;
    #1 chk(tag, 32'(act_vec_o), (exp == NONE) ? 32'(prev) : 32'(exp));
  endtask

  task automatic cmpl(logic [9:0] v, logic [9:0] exp_act, string tag);
    @(negedge clk);
    cmpl_req_i = 1'b1; cmpl_vec_i = v;
    @(negedge clk);
    cmpl_req_i = 1'b0;
    #1 chk(tag, 32'(act_vec_o), 32'(exp_act));
  endtask

  task automatic pulse_irq(logic [NEXT-1:0] m);
    @(negedge clk); irq_i = m;
    @(negedge clk); irq_i = '0;
  endtask

  task automatic pulse_sys(logic [15:0] m);
    @(negedge clk); sys_pend_i = m;
    @(negedge clk); sys_pend_i = '0;
  endtask

  task automatic t_reset;
    rd(0, 32'h0000_0800, "R1 status after reset");
    rd(6, 32'h0, "R1 handler word after reset");
    rd(3, 32'h0, "R1 priorities after reset");
    ack(NONE, "R1 R3 ack with nothing pending");
    rd(2, 32'h0, "R12 interrupt count word");
  endtask

  task automatic t_ext;
    pulse_irq(32'h20);
    rd(0, 32'h0040_0800, "R2 disabled line pending but not chosen");
    wr(8, 32'hFFFF_FFFF);
    rd(8, 32'hFFFF_FFFF, "R12 enable readback");
    rd(0, 32'h0041_5800, "R2 R7 line 5 is number 21");
    ack(10'd21, "R2 ack of line 5");
    rd(0, 32'h0000_0815, "R7 active 21 at base level");
    cmpl(10'd21, 10'd0, "R5 completion clears");
  endtask

  task automatic t_prio;
    wr(PRB, 32'h0200_0000);
    wr(PRB + 1, 32'h0100_0000);
    rd(PRB, 32'h0200_0000, "R10 ext priority readback");
    pulse_irq(32'h88);
    #1 chk("R4 lower value wins", 32'(pend_vec_o), 32'd23);
    wr(PRB, 32'h0100_0000);
    #1 chk("R4 tie goes to lower number", 32'(pend_vec_o), 32'd19);
    ack(10'd19, "R3 ack 19");
    ack(10'd23, "R3 nested ack 23");
    rd(0, 32'h0000_0017, "R7 nested status");
    cmpl(10'd19, 10'd23, "R5 mismatched completion ignored");
    cmpl(10'd23, 10'd19, "R5 restore preempted");
    cmpl(10'd19, 10'd0, "R5 back to base");
    wr(PRB, 32'h0);
    wr(PRB + 1, 32'h0);
  endtask

  task automatic t_nmi;
    wr(0, 32'h9000_0000);
    pulse_sys(16'h0008);
    rd(0, 32'h9000_2800, "R7 R8 nmi and pendsv pending");
    ack(10'd2, "R4 nmi first");
    rd(0, 32'h1000_3802, "R4 R7 hard fault next");
    ack(10'd3, "R4 hard fault");
    ack(10'd14, "R3 pendsv");
    rd(0, 32'h0000_000E, "R7 deep nesting status");
    cmpl(10'd14, 10'd3, "R5 pop to 3");
    cmpl(10'd3, 10'd2, "R5 pop to 2");
    cmpl(10'd2, 10'd0, "R5 pop to none");
  endtask

  task automatic t_setclr;
    wr(0, 32'h0600_0000);
    rd(0, 32'h0400_F800, "R8 tick set wins over clear");
    wr(0, 32'h0200_0000);
    rd(0, 32'h0000_0800, "R8 tick clear");
    wr(0, 32'h1800_0000);
    rd(0, 32'h1000_E800, "R8 pendsv set wins over clear");
    wr(0, 32'h0800_0000);
    rd(0, 32'h0000_0800, "R8 pendsv clear");
  endtask

  task automatic t_swtrig;
    wr(1, 32'd32);
    rd(0, 32'h0000_0800, "R9 id at limit ignored");
    wr(1, 32'd31);
    rd(0, 32'h0042_F800, "R9 id 31 pends 47");
    ack(10'd47, "R9 ack 47");
    cmpl(10'd47, 10'd0, "R9 complete 47");
  endtask

  task automatic t_sys;
    wr(3, 32'hFFEE_DDCC);
    rd(3, 32'h0F0E_0D0C, "R10 truncated priority readback");
    wr(6, 32'h0001_0000);
    pulse_sys(16'h0810);
    #1 chk("R10 byte0 is exc 4, svc lower value wins", 32'(pend_vec_o), 32'd11);
    rd(6, 32'h0001_A000, "R11 handler pend and enable");
    ack(10'd11, "R11 ack svc");
    rd(6, 32'h0001_2080, "R11 svc active bit");
    cmpl(10'd11, 10'd0, "R11 complete svc");
    wr(6, 32'h0);
    #1 chk("R11 disabled fault not chosen", 32'(pend_valid_o), 32'd0);
    ack(NONE, "R11 ack refused while disabled");
    rd(6, 32'h0000_2000, "R11 pending kept while disabled");
    wr(6, 32'h0001_0000);
    ack(10'd4, "R11 ack mem fault");
    cmpl(10'd4, 10'd0, "R11 complete mem fault");
    wr(3, 32'h0);
  endtask

  task automatic t_nest;
    pulse_irq(32'hF);
    ack(10'd16, "R6 depth 0");
    ack(10'd17, "R6 depth 1");
    ack(10'd18, "R6 depth 2");
    ack(NONE, "R6 full stack refuses");
    #1 chk("R6 candidate kept", 32'(pend_vec_o), 32'd19);
    @(negedge clk);
    ack_req_i = 1'b1; cmpl_req_i = 1'b1; cmpl_vec_i = 10'd18;
    #1 chk("R6 ack yields to completion", 32'(ack_vec_o), 32'(NONE));
    @(negedge clk);
    ack_req_i = 1'b0; cmpl_req_i = 1'b0;
    #1 chk("R6 completion applied", 32'(act_vec_o), 32'd17);
    ack(10'd19, "R6 room after pop");
    cmpl(10'd19, 10'd17, "R5 restore 17");
    cmpl(10'd17, 10'd16, "R5 restore 16");
    cmpl(10'd16, 10'd0, "R5 restore none");
    rd(0, 32'h0000_0800, "R7 idle at end");
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_ext();
    t_prio();
    t_nmi();
    t_setclr();
    t_swtrig();
    t_sys();
    t_nest();
    finish_run();
  end
endmodule